// File: doc/BRIEF.md
# Edge-Triggered Timestamp Capture Unit

This unit records the value of a free-running 32-bit time counter at the moment a trigger arrives. The trigger comes from one of two places: an asynchronous event pin, which is brought into the clock domain through a two-stage synchronizer and then edge-detected, or an internal pulse-per-second strobe that is already synchronous. A single capture channel holds one timestamp. Software reads it as two 16-bit words: the lower half on `stamp_lo` and the upper half on `stamp_hi`.

Capture works as a handshake. When the unit captures a stamp it raises a valid flag. Software re-arms the unit by writing the status word with the valid bit at 0. An event that arrives while valid is still set raises an error flag. Depending on an overwrite option in the configuration word, that event either replaces the stored stamp or is dropped. A saturating counter in the status word counts every event the unit accepts. Any status write clears the counter, and the same write chooses the trigger source.

The register strobes are single-cycle writes with no back-pressure. Triggers cannot be stalled, so nothing at the edge of the block handshakes. Its outputs are plain status levels.

Top module: `evcap_unit`

## Requirements
- R1: After reset the configuration is 0, the status word (`stat_rd`) is 0 and both stamp words are 0.
- R2: While configuration bit 2 (arm) is 0, no trigger is counted or captured, and the valid flag and stamp stay unchanged.
- R3: With configuration bit 0 = 0 and status bit 0 = 0, a rising edge on `ev_pin` captures `time_cnt` as it is in the cycle where the edge is detected. This is the third clock edge after the pin changes. Bits 15:0 of the stamp appear on `stamp_lo` and bits 31:16 appear on `stamp_hi`.
- R4: With configuration bit 0 = 1, only falling edges of `ev_pin` are triggers, and rising edges are ignored.
- R5: Status bit 0 selects the source. When it is 1, a clock cycle with `pps_pulse` high is a trigger and `ev_pin` is ignored. When it is 0, `ev_pin` edges are triggers and `pps_pulse` is ignored.
- R6: A trigger that arrives while valid (status bit 1) is 0 stores the stamp and sets valid.
- R7: A trigger that arrives while valid is 1 and overwrite (configuration bit 1) is 0 keeps the stored stamp and sets error (status bit 2).
- R8: A trigger that arrives while valid is 1 and overwrite is 1 replaces the stored stamp and sets error.
- R9: A status write clears the count (`stat_rd` bits 15:8) and loads the source from data bit 0. It clears valid when data bit 1 is 0 and clears error when data bit 2 is 0. A 1 in either of those bits leaves that flag unchanged.
- R10: The count goes up by one for every accepted trigger, whether the stamp is stored or missed, and it holds at 255.
- R11: When a status write and a trigger fall in the same cycle, the write is applied first and the trigger is then judged against the result. A write that clears valid together with a trigger therefore leaves valid = 1, error = 0, count = 1 and the new stamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 3 | Configuration: bit0 falling edge, bit1 overwrite, bit2 arm |
| stat_wr_en | input | 1 | Status write strobe |
| stat_wr_data | input | 3 | Status write: bit0 source, bit1 valid keep, bit2 error keep |
| ev_pin | input | 1 | Asynchronous event request pin |
| pps_pulse | input | 1 | Internal synchronous trigger strobe |
| time_cnt | input | 32 | Running time counter |
| stat_rd | output | 16 | Status: bit0 source, bit1 valid, bit2 error, 15:8 count |
| cfg_rd | output | 3 | Current configuration |
| stamp_lo | output | 16 | Captured time, bits 15:0 |
| stamp_hi | output | 16 | Captured time, bits 31:16 |

## Verification
A status write and an accepted trigger can land on the same clock edge. The write then clears valid, error and the count, while the trigger wants to set valid and increment the count. The bench provokes this by raising the status write strobe (clearing valid) and `pps_pulse` on the same negative clock edge. It then expects valid = 1, error = 0, count = 1 and the new stamp, which shows that the write ordering loses no event. The assertions cover the same collision: they exclude a clearing write from the missed-event check, and they check the count clear only when no trigger is present.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
  // configuration bit positions
  localparam int CFG_FALL  = 0;
  localparam int CFG_OVWR  = 1;
  localparam int CFG_ARM   = 2;
  localparam int CFG_W     = 3;
  // status bit positions
  localparam int ST_SRC    = 0;
  localparam int ST_VALID  = 1;
  localparam int ST_ERR    = 2;
  localparam int ST_WR_W   = 3;
  localparam int ST_CNT_LSB = 8;
endpackage

// File: rtl/evcap_sync_edge.sv
module evcap_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  input  logic falling,
  output logic edge_hit
);
  logic [STAGES-1:0] chain;
  logic              prev_lvl;
  logic              cur_lvl;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= pin_async;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], pin_async};
      end
    end
  endgenerate

  assign cur_lvl = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) prev_lvl <= 1'b0;
    else        prev_lvl <= cur_lvl;
  end

  assign edge_hit = falling ? (prev_lvl & ~cur_lvl) : (~prev_lvl & cur_lvl);
endmodule

// File: rtl/evcap_store.sv
module evcap_store #(
  parameter int TS_W  = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [TS_W-1:0]  time_in,
  input  logic             overwrite,
  input  logic             wr_en,
  input  logic             wr_src,
  input  logic             wr_keep_valid,
  input  logic             wr_keep_err,
  output logic             src_q,
  output logic             valid_q,
  output logic             err_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [TS_W-1:0]  ts_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             v_base;
  logic             e_base;
  logic [CNT_W-1:0] c_base;

  // a status write takes effect before a same-cycle trigger is judged
  always_comb begin
    v_base = wr_en ? (valid_q & wr_keep_valid) : valid_q;
    e_base = wr_en ? (err_q & wr_keep_err)     : err_q;
    c_base = wr_en ? '0 : cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q   <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      cnt_q   <= '0;
      ts_q    <= '0;
    end else begin
      if (wr_en) src_q <= wr_src;
      valid_q <= v_base;
      err_q   <= e_base;
      cnt_q   <= c_base;
      if (fire) begin
        cnt_q <= (c_base == CNT_MAX) ? CNT_MAX : c_base + 1'b1;
        if (!v_base) begin
          ts_q    <= time_in;
          valid_q <= 1'b1;
        end else begin
          err_q <= 1'b1;
          if (overwrite) ts_q <= time_in;
        end
      end
    end
  end
endmodule

// File: rtl/evcap_unit.sv
module evcap_unit #(
  parameter int TS_W        = 32,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr_en,
  input  logic [2:0]            cfg_wr_data,
  input  logic                  stat_wr_en,
  input  logic [2:0]            stat_wr_data,
  input  logic                  ev_pin,
  input  logic                  pps_pulse,
  input  logic [TS_W-1:0]       time_cnt,
  output logic [CNT_W+7:0]      stat_rd,
  output logic [2:0]            cfg_rd,
  output logic [TS_W/2-1:0]     stamp_lo,
  output logic [TS_W/2-1:0]     stamp_hi
);
  import evcap_pkg::*;
  localparam int HALF_W = TS_W / 2;

  logic [CFG_W-1:0] cfg_q;
  logic             pin_edge;
  logic             fire;
  logic             src_q;
  logic             valid_q;
  logic             err_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TS_W-1:0]  ts_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         cfg_q <= '0;
    else if (cfg_wr_en) cfg_q <= cfg_wr_data;
  end

  evcap_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (ev_pin),
    .falling   (cfg_q[CFG_FALL]),
    .edge_hit  (pin_edge)
  );

  assign fire = cfg_q[CFG_ARM] & (src_q ? pps_pulse : pin_edge);

  evcap_store #(.TS_W(TS_W), .CNT_W(CNT_W)) u_store (
    .clk           (clk),
    .rst_n         (rst_n),
    .fire          (fire),
    .time_in       (time_cnt),
    .overwrite     (cfg_q[CFG_OVWR]),
    .wr_en         (stat_wr_en),
    .wr_src        (stat_wr_data[ST_SRC]),
    .wr_keep_valid (stat_wr_data[ST_VALID]),
    .wr_keep_err   (stat_wr_data[ST_ERR]),
    .src_q         (src_q),
    .valid_q       (valid_q),
    .err_q         (err_q),
    .cnt_q         (cnt_q),
    .ts_q          (ts_q)
  );

  assign stat_rd  = {cnt_q, 5'b0, err_q, valid_q, src_q};
  assign cfg_rd   = cfg_q;
  assign stamp_lo = ts_q[HALF_W-1:0];
  assign stamp_hi = ts_q[TS_W-1:HALF_W];
endmodule

// File: rtl/evcap_unit_chk.sv
module evcap_unit_chk #(
  parameter int TS_W  = 32,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fire,
  input logic             stat_wr_en,
  input logic [2:0]       stat_wr_data,
  input logic [2:0]       cfg_q,
  input logic             valid_q,
  input logic             err_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [TS_W-1:0]  ts_q
);
  import evcap_pkg::*;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic clr_valid;
  assign clr_valid = stat_wr_en && !stat_wr_data[ST_VALID];

  // R9
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr_en && !fire) |=> (cnt_q == '0));
  // R6
  valid_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> valid_q);
  // R7
  miss_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && valid_q && !clr_valid) |=> err_q);
  // R7
  keep_ts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && valid_q && !clr_valid && !cfg_q[CFG_OVWR]) |=> $stable(ts_q));
  // R10
  sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_wr_en && cnt_q == CMAX) |=> (cnt_q == CMAX));
  // R2
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[CFG_ARM] && !stat_wr_en) |=> ($stable(cnt_q) && $stable(valid_q) && $stable(ts_q)));
endmodule

bind evcap_unit evcap_unit_chk #(.TS_W(TS_W), .CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .fire         (fire),
  .stat_wr_en   (stat_wr_en),
  .stat_wr_data (stat_wr_data),
  .cfg_q        (cfg_q),
  .valid_q      (valid_q),
  .err_q        (err_q),
  .cnt_q        (cnt_q),
  .ts_q         (ts_q)
);

// File: tb/evcap_unit_tb_top.sv
module evcap_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [2:0]  cfg_wr_data = '0;
  logic        stat_wr_en = 1'b0;
  logic [2:0]  stat_wr_data = '0;
  logic        ev_pin = 1'b0;
  logic        pps_pulse = 1'b0;
  logic [31:0] time_cnt = '0;
  logic [15:0] stat_rd;
  logic [2:0]  cfg_rd;
  logic [15:0] stamp_lo;
  logic [15:0] stamp_hi;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  evcap_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data), .ev_pin(ev_pin),
    .pps_pulse(pps_pulse), .time_cnt(time_cnt), .stat_rd(stat_rd), .cfg_rd(cfg_rd),
    .stamp_lo(stamp_lo), .stamp_hi(stamp_hi)
  );

  typedef struct packed {
    logic [1:0]  op;    // 0 pin level, 1 pps strobe, 2 status write
    logic [2:0]  arg;
    logic [31:0] tval;
    logic [31:0] ets;
    logic        ev;
    logic        ee;
    logic [7:0]  ecnt;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 3'd0, 32'h0000_0001, 32'h0000_0000, 1'b0, 1'b0, 8'd0, 8'd5},  // R5 pps ignored
    '{2'd0, 3'd1, 32'h1234_5678, 32'h1234_5678, 1'b1, 1'b0, 8'd1, 8'd3},  // R3 rising capture
    '{2'd0, 3'd0, 32'hAAAA_0000, 32'h1234_5678, 1'b1, 1'b0, 8'd1, 8'd3},  // R3 falling ignored
    '{2'd0, 3'd1, 32'h0000_0111, 32'h1234_5678, 1'b1, 1'b1, 8'd2, 8'd7},  // R7 miss, kept
    '{2'd2, 3'd0, 32'h0000_0000, 32'h1234_5678, 1'b0, 1'b0, 8'd0, 8'd9},  // R9 clear
    '{2'd0, 3'd0, 32'h0BAD_F00D, 32'h1234_5678, 1'b0, 1'b0, 8'd0, 8'd3},  // R3 no edge
    '{2'd0, 3'd1, 32'h0000_BEEF, 32'h0000_BEEF, 1'b1, 1'b0, 8'd1, 8'd6},  // R6 valid set
    '{2'd2, 3'd1, 32'h0000_0000, 32'h0000_BEEF, 1'b0, 1'b0, 8'd0, 8'd9},  // R9 src internal
    '{2'd0, 3'd0, 32'h0000_0077, 32'h0000_BEEF, 1'b0, 1'b0, 8'd0, 8'd5},  // R5 pin ignored
    '{2'd0, 3'd1, 32'h0000_0078, 32'h0000_BEEF, 1'b0, 1'b0, 8'd0, 8'd5},  // R5 pin ignored
    '{2'd1, 3'd0, 32'hCAFE_0001, 32'hCAFE_0001, 1'b1, 1'b0, 8'd1, 8'd5},  // R5 pps capture
    '{2'd2, 3'd6, 32'h0000_0000, 32'hCAFE_0001, 1'b1, 1'b0, 8'd0, 8'd9}   // R9 keep bits
  };

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", what, got, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic [31:0] ets, input logic ev,
                           input logic ee, input logic [7:0] ecnt);
    check({tag, " stamp"}, {stamp_hi, stamp_lo}, ets);
    check({tag, " status"}, {16'h0, stat_rd[15:8], 5'b0, stat_rd[2:1], 1'b0},
          {16'h0, ecnt, 5'b0, ee, ev, 1'b0});
  endtask

  task automatic do_cfg(input logic [2:0] d);
    @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_data = d;
    @(negedge clk); cfg_wr_en = 1'b0;
  endtask

  task automatic do_sts(input logic [2:0] d);
    @(negedge clk); stat_wr_en = 1'b1; stat_wr_data = d;
    @(negedge clk); stat_wr_en = 1'b0;
  endtask

  task automatic do_pps(input logic [31:0] t);
    @(negedge clk); time_cnt = t; pps_pulse = 1'b1;
    @(negedge clk); pps_pulse = 1'b0;
  endtask

  task automatic do_pin(input logic lvl, input logic [31:0] t);
    @(negedge clk); time_cnt = t; ev_pin = lvl;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 stat", {16'h0, stat_rd}, 32'h0);
    check("R1 cfg", {29'h0, cfg_rd}, 32'h0);
    check("R1 stamp", {stamp_hi, stamp_lo}, 32'h0);

    do_cfg(3'b100);  // arm, rising, no overwrite
    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        2'd0: do_pin(VECS[i].arg[0], VECS[i].tval);
        2'd1: do_pps(VECS[i].tval);
        default: do_sts(VECS[i].arg);
      endcase
      check_all($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].ets,
                VECS[i].ev, VECS[i].ee, VECS[i].ecnt);
    end

    // R8 overwrite replaces stamp and flags error
    do_sts(3'b001);
    do_cfg(3'b110);
    do_pps(32'h0000_0100);
    do_pps(32'h0000_0200);
    check_all("R8 overwrite", 32'h0000_0200, 1'b1, 1'b1, 8'd2);

    // R11 clearing write and trigger in the same cycle
    @(negedge clk);
    time_cnt = 32'h0000_0300; pps_pulse = 1'b1;
    stat_wr_en = 1'b1; stat_wr_data = 3'b001;
    @(negedge clk);
    pps_pulse = 1'b0; stat_wr_en = 1'b0;
    check_all("R11 collision", 32'h0000_0300, 1'b1, 1'b0, 8'd1);

    // R10 saturation
    for (int k = 0; k < 300; k++) do_pps(32'h0000_0400);
    check_all("R10 saturate", 32'h0000_0400, 1'b1, 1'b1, 8'd255);

    // R2 disarmed
    do_cfg(3'b000);
    do_sts(3'b001);
    do_pps(32'h0000_0999);
    check_all("R2 disarmed", 32'h0000_0400, 1'b0, 1'b0, 8'd0);

    // R4 falling edge mode (pin currently high)
    do_cfg(3'b101);
    do_sts(3'b000);
    do_pin(1'b0, 32'h0000_0500);
    check_all("R4 falling capture", 32'h0000_0500, 1'b1, 1'b0, 8'd1);
    do_sts(3'b000);
    do_pin(1'b1, 32'h0000_0600);
    check_all("R4 rising ignored", 32'h0000_0500, 1'b0, 1'b0, 8'd0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule